// File: doc/BRIEF.md
# SDRAM Burst Sequencer (single bank)

This block is the command and burst control core of a synchronous DRAM device, for one bank. On each rising clock edge with clock enable high it decodes the four active-low command pins into one of: no-op, row open, column read, column write, burst stop, row close and mode load. A mode register holds the burst length and the read latency. After a column command the block works out the following column addresses by itself, so the controller sends only the first column.

Read data leaves through a short latency pipeline and appears two or three cycles after the read command, one word per cycle after that. Write data enters with the write command and on each following cycle of the burst. A burst can be cut short by a stop command or by any other command. Holding the clock enable low freezes the column counter, the output pipeline and the outputs, and the burst resumes where it stopped. A column command with no open row has no effect and raises an error flag for one cycle. The storage is a small behavioural array of rows by columns.

Top module: `sdram_burst_seq`

## Requirements
- R1: With `cke` high, `{cs_n,ras_n,cas_n,we_n}` is decoded at each rising edge: `1xxx` and `0111` no-op, `0011` open row `addr[ROW_W-1:0]`, `0101` read from column `addr[COL_W-1:0]`, `0100` write to that column, `0110` burst stop, `0010` close row, `0000` mode load, `0001` no-op.
- R2: Mode load takes the burst length from `addr[2:0]` (`000`=1, `001`=2, `010`=4, `011`=8, `111`=full page of 16, any other code=1). It takes the read latency from `addr[6:4]` (`010`=2, any other code=3).
- R3: A read sampled at edge E gives its first word with `rvalid` high right after edge E+CL. It then gives one word per cycle, with exactly burst-length words.
- R4: Burst word k comes from column `(s div BL)*BL + ((s mod BL)+k) mod BL` for start column s: the column wraps inside the aligned block of BL columns.
- R5: In full-page mode word k comes from column `(s+k) mod 16`. The burst wraps at the page end and runs until another command ends it.
- R6: A write stores `wdata` at the write edge into the start column. It stores `wdata` of each following edge into the next column in the R4/R5 order. After BL words, further `wdata` is not stored.
- R7: A stop command sampled k edges after a read (k>=1) leaves min(k,BL) words. For a write it leaves the words of the write edge and of the k-1 edges before the stop, and the stop edge stores nothing.
- R8: Row open, row close, mode load and a new column command also end a running burst, in the same way as a stop. Row close also closes the row.
- R9: While `cke` is low no command is taken, no word is stored, and `rdata`, `rvalid`, `cmd_err` and the burst position hold. After `cke` returns high the burst continues with the next word.
- R10: A read or write with no open row starts no burst, stores nothing and sets `cmd_err` high for the one cycle after that edge.
- R11: After reset `rvalid`, `rdata` and `cmd_err` are 0, no row is open, the burst length is 1 and the read latency is 2.
- R12: `rdata` is 0 whenever `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| cke | input | 1 | Clock enable; low freezes the block |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row command pin, active low |
| cas_n | input | 1 | Column command pin, active low |
| we_n | input | 1 | Write command pin, active low |
| addr | input | ADDR_W (7) | Row, column or mode field |
| wdata | input | DATA_W (8) | Write data |
| rdata | output | DATA_W (8) | Read data, 0 when not valid |
| rvalid | output | 1 | Read data valid |
| cmd_err | output | 1 | Column command with no open row |

## Verification
A read taken at edge E has word k due right after edge E+CL+k. The bench drives each command at a falling edge and reads the outputs at the next falling edge, before it drives again, so the observation after edge E+e is compared with word e-CL. The bench also checks that the cycles before and after the burst show `rvalid` low. Write words go into the array at the same edge as their command, so the bench checks them later with reads. `cmd_err` is due in the cycle just after the bad command and must be low again in the cycle after that. During a freeze the bench checks that each frozen cycle repeats the last observation, and that the word after the freeze is word e+1.

// File: rtl/sdram_seq_pkg.sv
// Shared command type, mode field positions and pin decoder for the
// burst sequencer. Assumes the active-low four-pin command encoding.
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_ACT  = 3'd1,
        CMD_RD   = 3'd2,
        CMD_WR   = 3'd3,
        CMD_TERM = 3'd4,
        CMD_PRE  = 3'd5,
        CMD_MRS  = 3'd6
    } cmd_e;

    // Mode field positions inside the address bus
    localparam int BL_LSB = 0;
    localparam int BL_MSB = 2;
    localparam int CL_LSB = 4;
    localparam int CL_MSB = 6;

    // Map the four command pins to an operation; deselect and refresh are no-ops
    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_NOP;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                3'b110:  c = CMD_TERM;
                3'b010:  c = CMD_PRE;
                3'b000:  c = CMD_MRS;
                default: c = CMD_NOP;
            endcase
        end
        return c;
    endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
// Command decoder: turns the sampled pins into one operation per cycle.
// Assumes pins are stable around the rising edge; cke low yields a no-op.
module sdram_cmd_decode
    import sdram_seq_pkg::*;
(
    input  logic cke,
    input  logic cs_n,
    input  logic ras_n,
    input  logic cas_n,
    input  logic we_n,
    output cmd_e cmd
);

    // Decode pins, masking everything while the clock is disabled
    always_comb begin
        cmd = cke ? decode_pins(cs_n, ras_n, cas_n, we_n) : CMD_NOP;
    end

endmodule

// File: rtl/sdram_mode_reg.sv
// Mode register: holds the burst-length code and latency choice and
// presents the decoded burst length. Assumes COL_W >= 3 so that a burst
// of 8 fits inside one page.
module sdram_mode_reg #(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [2:0]       bl_field,
    input  logic [2:0]       cl_field,
    output logic             full_page,
    output logic [COL_W-1:0] len_m1,
    output logic             cl3
);

    logic [2:0] bl_q;

    // Capture the mode fields on a mode-load command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bl_q <= 3'b000;
            cl3  <= 1'b0;
        end else if (en && load) begin
            bl_q <= bl_field;
            cl3  <= (cl_field != 3'd2);
        end
    end

    // Turn the burst-length code into a last-offset value
    always_comb begin
        full_page = (bl_q == 3'b111);
        case (bl_q)
            3'b001:  len_m1 = COL_W'(1);
            3'b010:  len_m1 = COL_W'(3);
            3'b011:  len_m1 = COL_W'(7);
            default: len_m1 = '0;
        endcase
    end

endmodule

// File: rtl/sdram_burst_engine.sv
// Burst engine: latches the start column and length of a column command
// and steps an offset once per enabled cycle. The column wraps inside the
// aligned burst block, or across the page in full-page mode. Any command
// other than a no-op ends the running burst.
module sdram_burst_engine
    import sdram_seq_pkg::*;
#(
    parameter int COL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  cmd_e             cmd,
    input  logic             row_open,
    input  logic [COL_W-1:0] col_in,
    input  logic             full_in,
    input  logic [COL_W-1:0] len_m1_in,
    output logic             busy,
    output logic             rd_emit,
    output logic [COL_W-1:0] rd_col,
    output logic             wr_en,
    output logic [COL_W-1:0] wr_col
);

    logic             active;
    logic             is_wr;
    logic             full_q;
    logic [COL_W-1:0] len_q;
    logic [COL_W-1:0] start_q;
    logic [COL_W-1:0] off_q;
    logic [COL_W-1:0] sum;
    logic [COL_W-1:0] cur_col;

    // Current column: linear in full-page mode, wrapped in the block otherwise
    always_comb begin
        sum     = start_q + off_q;
        cur_col = full_q ? sum : ((start_q & ~len_q) | (sum & len_q));
    end

    // Read word leaves on every active cycle; write word is stored only on no-ops
    always_comb begin
        busy    = active;
        rd_emit = active && !is_wr;
        rd_col  = cur_col;
        wr_en   = 1'b0;
        wr_col  = cur_col;
        if (en && cmd == CMD_WR && row_open) begin
            wr_en  = 1'b1;
            wr_col = col_in;
        end else if (en && active && is_wr && cmd == CMD_NOP) begin
            wr_en = 1'b1;
        end
    end

    // Burst state: load on column commands, step on no-ops, stop on others
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            is_wr   <= 1'b0;
            full_q  <= 1'b0;
            len_q   <= '0;
            start_q <= '0;
            off_q   <= '0;
        end else if (en) begin
            case (cmd)
                CMD_RD: begin
                    if (row_open) begin
                        active  <= 1'b1;
                        is_wr   <= 1'b0;
                        full_q  <= full_in;
                        len_q   <= len_m1_in;
                        start_q <= col_in;
                        off_q   <= '0;
                    end
                end
                CMD_WR: begin
                    if (row_open) begin
                        active  <= full_in || (len_m1_in != '0);
                        is_wr   <= 1'b1;
                        full_q  <= full_in;
                        len_q   <= len_m1_in;
                        start_q <= col_in;
                        off_q   <= COL_W'(1);
                    end
                end
                CMD_NOP: begin
                    if (active) begin
                        off_q <= off_q + COL_W'(1);
                        if (!full_q && off_q == len_q) begin
                            active <= 1'b0;
                        end
                    end
                end
                default: begin
                    active <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdram_read_pipe.sv
// Read latency pipeline: a chain of DEPTH registers fed by the array read.
// The output tap is stage DEPTH-2 or DEPTH-1, chosen by the latency bit.
// Assumes the latency is changed only while the pipeline is empty.
module sdram_read_pipe #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              sel_last,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [DEPTH-1:0]  v;
    logic [DATA_W-1:0] d [DEPTH];

    // First stage: capture the word, zero when no word leaves
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v[0] <= 1'b0;
            d[0] <= '0;
        end else if (en) begin
            v[0] <= in_valid;
            d[0] <= in_valid ? in_data : '0;
        end
    end

    for (genvar g = 1; g < DEPTH; g++) begin : g_stage
        // Later stages: shift one step per enabled cycle
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v[g] <= 1'b0;
                d[g] <= '0;
            end else if (en) begin
                v[g] <= v[g-1];
                d[g] <= d[g-1];
            end
        end
    end

    // Output tap selected by the latency setting
    always_comb begin
        out_valid = sel_last ? v[DEPTH-1] : v[DEPTH-2];
        out_data  = sel_last ? d[DEPTH-1] : d[DEPTH-2];
    end

endmodule

// File: rtl/sdram_burst_seq.sv
// Top of the single-bank burst sequencer: command decode, mode register,
// open-row tracking, burst engine, storage array and read pipeline.
// Assumes ADDR_W >= 7 and ADDR_W >= ROW_W, COL_W. The array is behavioural
// and has no reset; control state resets synchronously on rst_n low.
module sdram_burst_seq
    import sdram_seq_pkg::*;
#(
    parameter int ROW_W  = 3,
    parameter int COL_W  = 4,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              cmd_err
);

    localparam int WORDS   = (1 << ROW_W) * (1 << COL_W);
    localparam int IDX_W   = ROW_W + COL_W;
    localparam int LAT_MAX = 3;

    cmd_e              cmd;
    logic              row_open;
    logic [ROW_W-1:0]  row_q;
    logic              full_page;
    logic [COL_W-1:0]  len_m1;
    logic              cl3;
    logic              burst_busy;
    logic              rd_emit;
    logic [COL_W-1:0]  rd_col;
    logic              wr_en;
    logic [COL_W-1:0]  wr_col;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] mem [WORDS];

    sdram_cmd_decode u_dec (
        .cke   (cke),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .cmd   (cmd)
    );

    sdram_mode_reg #(.COL_W(COL_W)) u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke),
        .load      (cmd == CMD_MRS),
        .bl_field  (addr[BL_MSB:BL_LSB]),
        .cl_field  (addr[CL_MSB:CL_LSB]),
        .full_page (full_page),
        .len_m1    (len_m1),
        .cl3       (cl3)
    );

    // Open-row tracking: row open stores the row, row close clears it
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_open <= 1'b0;
            row_q    <= '0;
        end else if (cke) begin
            if (cmd == CMD_ACT) begin
                row_open <= 1'b1;
                row_q    <= addr[ROW_W-1:0];
            end else if (cmd == CMD_PRE) begin
                row_open <= 1'b0;
            end
        end
    end

    // Error flag: one cycle after a column command with no open row
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_err <= 1'b0;
        end else if (cke) begin
            cmd_err <= (cmd == CMD_RD || cmd == CMD_WR) && !row_open;
        end
    end

    sdram_burst_engine #(.COL_W(COL_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke),
        .cmd       (cmd),
        .row_open  (row_open),
        .col_in    (addr[COL_W-1:0]),
        .full_in   (full_page),
        .len_m1_in (len_m1),
        .busy      (burst_busy),
        .rd_emit   (rd_emit),
        .rd_col    (rd_col),
        .wr_en     (wr_en),
        .wr_col    (wr_col)
    );

    // Storage write: one word per write beat into the open row
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[IDX_W'({row_q, wr_col})] <= wdata;
        end
    end

    // Storage read of the current burst column
    always_comb begin
        rd_word = mem[IDX_W'({row_q, rd_col})];
    end

    sdram_read_pipe #(.DATA_W(DATA_W), .DEPTH(LAT_MAX)) u_pipe (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cke),
        .in_valid  (rd_emit),
        .in_data   (rd_word),
        .sel_last  (cl3),
        .out_valid (rvalid),
        .out_data  (rdata)
    );

endmodule

// File: rtl/sdram_burst_seq_chk.sv
// Checker for the burst sequencer: properties over pins and the open-row,
// busy and latency state. Attached to every instance by the bind below.
module sdram_burst_seq_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke,
    input logic              cs_n,
    input logic              ras_n,
    input logic              cas_n,
    input logic              we_n,
    input logic [2:0]        mrs_cl,
    input logic [DATA_W-1:0] rdata,
    input logic              rvalid,
    input logic              cmd_err,
    input logic              row_open,
    input logic              burst_busy,
    input logic              cl3
);

    p_col_no_row_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && ras_n && !cas_n && !row_open) |=> (cmd_err && !burst_busy));

    p_freeze_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |=> ($stable(rdata) && $stable(rvalid) && $stable(cmd_err) && $stable(burst_busy)));

    p_stop_ends_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && ras_n && cas_n && !we_n) |=> !burst_busy);

    p_close_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && cas_n && !we_n) |=> (!row_open && !burst_busy));

    p_mode_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cke && !cs_n && !ras_n && !cas_n && !we_n) |=> (cl3 == ($past(mrs_cl) != 3'd2)));

    p_idle_data_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0));

endmodule

bind sdram_burst_seq sdram_burst_seq_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cke        (cke),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .mrs_cl     (addr[6:4]),
    .rdata      (rdata),
    .rvalid     (rvalid),
    .cmd_err    (cmd_err),
    .row_open   (row_open),
    .burst_busy (burst_busy),
    .cl3        (cl3)
);

// File: tb/tb_sdram_burst_seq.sv
// Self-checking bench: sweeps burst length, latency and start column over
// one row, plus stop, freeze, error and write-order cases.
module tb_sdram_burst_seq;

    localparam logic [3:0] C_NOP  = 4'b0111;
    localparam logic [3:0] C_ACT  = 4'b0011;
    localparam logic [3:0] C_RD   = 4'b0101;
    localparam logic [3:0] C_WR   = 4'b0100;
    localparam logic [3:0] C_TERM = 4'b0110;
    localparam logic [3:0] C_PRE  = 4'b0010;
    localparam logic [3:0] C_MRS  = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cke = 1'b1;
    logic       cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid;
    logic       cmd_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;
    logic [7:0] model [128];
    logic       obs_v, obs_e;
    logic [7:0] obs_d;

    always #5 clk = ~clk;

    sdram_burst_seq dut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .cmd_err(cmd_err)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Observe outputs after the last edge, then drive the next command
    task automatic step(input logic [3:0] c, input int a, input int wd, input logic ck);
        @(negedge clk);
        obs_v = rvalid;
        obs_d = rdata;
        obs_e = cmd_err;
        {cs_n, ras_n, cas_n, we_n} = c;
        addr  = a[6:0];
        wdata = wd[7:0];
        cke   = ck;
    endtask

    function automatic int bcol(input int s, input int bl, input int k);
        if (bl == 0) return (s + k) % 16;
        return (s / bl) * bl + ((s % bl) + k) % bl;
    endfunction

    task automatic set_mode(input int blc, input int cl);
        step(C_MRS, (cl << 4) | blc, 0, 1'b1);
    endtask

    // Check observation e edges after a read edge
    task automatic check_beat(input int row, input int s, input int bl, input int cl,
                              input int nb, input int e);
        int k;
        int expd;
        k = e - cl;
        expd = (k >= 0 && k < nb) ? int'(model[row * 16 + bcol(s, bl, k)]) : 0;
        chk("R3", $sformatf("rvalid s=%0d bl=%0d cl=%0d e=%0d", s, bl, cl, e),
            int'(obs_v), (k >= 0 && k < nb) ? 1 : 0);
        chk(bl == 0 ? "R5" : "R4", $sformatf("rdata s=%0d bl=%0d cl=%0d e=%0d", s, bl, cl, e),
            int'(obs_d), expd);
    endtask

    // Read burst; bl 0 is full page; stop_k>0 sends stop_c at edge E+stop_k;
    // fz>=0 freezes three edges after observation fz
    task automatic run_read(input int row, input int s, input int bl, input int cl,
                            input int stop_k, input logic [3:0] stop_c, input int fz);
        int nb;
        logic [3:0] c;
        logic       hv;
        logic [7:0] hd;
        if (stop_k > 0) nb = (bl == 0 || stop_k < bl) ? stop_k : bl;
        else nb = bl;
        step(C_RD, s, 0, 1'b1);
        for (int e = 0; e <= cl + nb + 1; e++) begin
            c = (stop_k > 0 && e == stop_k - 1) ? stop_c : C_NOP;
            step(c, 0, 0, (e == fz) ? 1'b0 : 1'b1);
            check_beat(row, s, bl, cl, nb, e);
            if (e == fz) begin
                hv = obs_v;
                hd = obs_d;
                for (int f = 0; f < 3; f++) begin
                    step(C_NOP, 0, 0, (f < 2) ? 1'b0 : 1'b1);
                    chk("R9", "frozen rvalid", int'(obs_v), int'(hv));
                    chk("R9", "frozen rdata", int'(obs_d), int'(hd));
                end
            end
        end
    endtask

    // Write burst with data seed+11*j; stop_k>0 sends a stop at edge E+stop_k
    task automatic run_write(input int row, input int s, input int bl,
                             input int stop_k, input int seed);
        int nb;
        if (stop_k > 0) nb = (bl == 0 || stop_k < bl) ? stop_k : bl;
        else nb = bl;
        for (int j = 0; j < nb; j++) begin
            step(j == 0 ? C_WR : C_NOP, s, (seed + 11 * j) & 255, 1'b1);
            model[row * 16 + bcol(s, bl, j)] = 8'((seed + 11 * j) & 255);
        end
        // Stop edge or the edge after the burst: this word must not be stored
        step((stop_k > 0) ? C_TERM : C_NOP, 0, 8'hEE, 1'b1);
        step(C_NOP, 0, 0, 1'b1);
    endtask

    initial begin
        for (int i = 0; i < 128; i++) model[i] = 8'h00;
        repeat (4) step(C_NOP, 0, 0, 1'b1);
        rst_n = 1'b1;
        step(C_NOP, 0, 0, 1'b1);
        step(C_NOP, 0, 0, 1'b1);
        chk("R11", "rvalid after reset", int'(obs_v), 0);
        chk("R11", "rdata after reset", int'(obs_d), 0);
        chk("R11", "cmd_err after reset", int'(obs_e), 0);

        // Reset mode: burst of 1, latency 2
        step(C_ACT, 1, 0, 1'b1);
        run_write(1, 5, 1, 0, 8'h3C);
        run_read(1, 5, 1, 2, 0, C_NOP, -1);
        step(C_PRE, 0, 0, 1'b1);

        // Fill every row with full-page writes stopped after 16 words (R5, R6)
        set_mode(7, 2);
        for (int r = 0; r < 8; r++) begin
            step(C_ACT, r, 0, 1'b1);
            run_write(r, 0, 0, 16, r * 37 + 5);
            step(C_PRE, 0, 0, 1'b1);
        end

        // Sweep latency, burst length and start column (R1, R2, R3, R4)
        for (int cl = 2; cl <= 3; cl++) begin
            for (int blc = 0; blc < 4; blc++) begin
                set_mode(blc, cl);
                step(C_ACT, (blc + cl) % 8, 0, 1'b1);
                for (int s = 0; s < 16; s++)
                    run_read((blc + cl) % 8, s, 1 << blc, cl, 0, C_NOP, -1);
                step(C_PRE, 0, 0, 1'b1);
            end
        end

        step(C_ACT, 3, 0, 1'b1);
        // Full page read wraps past column 15, stopped after 20 words (R5)
        set_mode(7, 3);
        run_read(3, 11, 0, 3, 20, C_TERM, -1);
        // Freeze in the middle of a burst of 8 (R9)
        set_mode(3, 2);
        run_read(3, 5, 8, 2, 0, C_NOP, 3);
        // Stop after 3 and after 1 words (R7)
        set_mode(3, 3);
        run_read(3, 2, 8, 3, 3, C_TERM, -1);
        set_mode(2, 2);
        run_read(3, 9, 4, 2, 1, C_TERM, -1);
        // Write order with wrap and write stop (R6, R7)
        run_write(3, 6, 4, 0, 8'h90);
        set_mode(3, 2);
        run_write(3, 8, 8, 3, 8'h41);
        run_read(3, 0, 8, 2, 0, C_NOP, -1);
        run_read(3, 8, 8, 2, 0, C_NOP, -1);
        // Reserved length code gives one word (R2)
        set_mode(4, 2);
        run_read(3, 7, 1, 2, 0, C_NOP, -1);
        // Row close ends a burst after 2 words (R8)
        set_mode(3, 2);
        run_read(3, 4, 8, 2, 2, C_PRE, -1);

        // Column commands with no open row (R10)
        step(C_RD, 3, 0, 1'b1);
        step(C_NOP, 0, 0, 1'b1);
        chk("R10", "cmd_err after read with no row", int'(obs_e), 1);
        chk("R10", "rvalid after read with no row", int'(obs_v), 0);
        step(C_WR, 9, 8'h99, 1'b1);
        chk("R10", "cmd_err one cycle only", int'(obs_e), 0);
        step(C_NOP, 0, 0, 1'b1);
        chk("R10", "cmd_err after write with no row", int'(obs_e), 1);
        for (int i = 0; i < 4; i++) begin
            step(C_NOP, 0, 0, 1'b1);
            chk("R10", "no read data after bad read", int'(obs_v), 0);
        end
        step(C_ACT, 3, 0, 1'b1);
        set_mode(0, 2);
        run_read(3, 9, 1, 2, 0, C_NOP, -1);
        step(C_PRE, 0, 0, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

endmodule